// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block turns eight asynchronous general-purpose input pins into interrupt requests. Each pin is first brought into the clock domain through a synchronizer. It is then qualified as either a level source or an edge source. For a level source, the active polarity is selectable. For an edge source, the pin can trigger on the rising edge, on the falling edge, or on both. Edge events are latched until software clears them. Level events follow the pin directly. A per-pin enable masks the raw status, and the masked status drives four interrupt lines. Pins 0, 1 and 2 each own one line. Pins 3 to 7 share the fourth line.

Software uses a byte-wide register port. It has a write strobe, a 3-bit register select, write data, and read data that follows the select combinationally. The register selects are:

| Select | Register | Access |
|---|---|---|
| 0 | sense (1 = level, 0 = edge) | read/write |
| 1 | both-edges | read/write |
| 2 | polarity (1 = high level or rising edge, 0 = low level or falling edge) | read/write |
| 3 | enable | read/write |
| 4 | raw status | read only |
| 5 | masked status | read only |
| 6 | clear (write one to clear) | write only |
| 7 | unused | — |

Bit n of every register belongs to pin n.

The block has no central state machine. Each pin's edge latch has two states:
- **Idle.** It moves to **Pending** on a qualified edge.
- **Pending.** It moves back to **Idle** on a clear write that has no coinciding edge.
- Level mode forces the latch into **Idle**.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every configuration, enable and status bit reads 0 and all four interrupt lines are low.
- R2: Writes to selects 0 (sense), 1 (both-edges), 2 (polarity) and 3 (enable) take effect on the clock edge of the write, and each register reads back the written byte.
- R3: For a pin whose sense bit is 1, raw status bit n (select 4) equals the synchronized pin when polarity bit n is 1, and its inverse when polarity bit n is 0. The pin passes through two synchronizer flops. A clear write does not change this bit, and switching a pin to level mode discards any latched edge.
- R4: For a pin whose sense bit is 0 and whose both-edges bit is 0, a rising edge (polarity 1) or a falling edge (polarity 0) sets raw status bit n. The bit is visible two clock edges after the synchronizer's first flop captures the change.
- R5: With both-edges bit n set on an edge pin, either edge sets raw status bit n, whatever polarity bit n holds.
- R6: A latched edge bit stays set until a write to select 6 with data bit n = 1. Zero data bits leave the other latched bits unchanged.
- R7: If a qualified edge and a clear of the same bit fall on the same clock edge, the bit stays set.
- R8: Masked status (select 5) reads as raw status AND enable.
- R9: Interrupt line k equals masked bit k for k = 0, 1, 2. Line 3 is the OR of masked bits 3 to 7.
- R10: Writes to selects 4, 5 and 7 change nothing. Selects 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous pin levels |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 4 | Interrupt lines: three direct lines and one shared line |

## Verification
The corner cases that matter most are these:
- **An edge coinciding with a clear.** A design that gives the clear priority drops that event.
- **Both-edges mode with the opposite polarity.** A design that still honours polarity misses every other edge.
- **A clear written to a level pin.** A design that clears level status would show a glitch while the pin is still active.
- **Edge-to-level switching.** A stale latch would reappear when the pin goes back to edge mode.
- **The shared line.** A wrong fold would either miss pins 3 to 7 or leak unmasked pins onto the line.

A behavioural model is compared on every clock with the interrupt lines and with the selected register. Random register traffic and pin toggling run alongside the directed cases.

// File: rtl/gid_pkg.sv
package gid_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_SENSE  = 3'd0,
        SEL_BOTH   = 3'd1,
        SEL_POL    = 3'd2,
        SEL_ENABLE = 3'd3,
        SEL_RAW    = 3'd4,
        SEL_MASKED = 3'd5,
        SEL_CLEAR  = 3'd6,
        SEL_SPARE  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gid_sync.sv
module gid_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [STAGES-1:0][W-1:0] chain_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/gid_pin_detect.sv
module gid_pin_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic prev_i,
    input  logic sense_i,
    input  logic both_i,
    input  logic pol_i,
    input  logic clr_i,
    output logic raw_o
);
    logic rise, fall, hit, lvl;
    logic lat_q, lat_d;

    assign rise  = sync_i & ~prev_i;
    assign fall  = ~sync_i & prev_i;
    assign hit   = both_i ? (rise | fall) : (pol_i ? rise : fall);
    assign lvl   = pol_i ? sync_i : ~sync_i;
    assign lat_d = sense_i ? 1'b0 : (hit | (lat_q & ~clr_i));
    assign raw_o = sense_i ? lvl : lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= 1'b0;
        else        lat_q <= lat_d;
    end

    // R7: an edge wins against a clear on the same edge
    a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_i && hit && clr_i) |=> lat_q);
    // R6: a pending bit holds without a clear
    a_r6_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_i && lat_q && !clr_i) |=> lat_q);
    // R6: a clear without an edge empties the latch
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_i && lat_q && clr_i && !hit) |=> !lat_q);
    // R3: level mode leaves no latched edge behind
    a_r3_level_discards: assert property (@(posedge clk) disable iff (!rst_n)
        sense_i |=> !lat_q);
endmodule

// File: rtl/gid_regs.sv
module gid_regs
    import gid_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [SEL_W-1:0] addr_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [W-1:0]     raw_i,
    input  logic [W-1:0]     masked_i,
    output logic [W-1:0]     sense_o,
    output logic [W-1:0]     both_o,
    output logic [W-1:0]     pol_o,
    output logic [W-1:0]     en_o,
    output logic [W-1:0]     clr_o,
    output logic [W-1:0]     rdata_o
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_o <= '0;
            both_o  <= '0;
            pol_o   <= '0;
            en_o    <= '0;
        end else if (we_i) begin
            unique case (sel)
                SEL_SENSE:  sense_o <= wdata_i;
                SEL_BOTH:   both_o  <= wdata_i;
                SEL_POL:    pol_o   <= wdata_i;
                SEL_ENABLE: en_o    <= wdata_i;
                default:    ;
            endcase
        end
    end

    assign clr_o = (we_i && sel == SEL_CLEAR) ? wdata_i : '0;

    always_comb begin
        unique case (sel)
            SEL_SENSE:  rdata_o = sense_o;
            SEL_BOTH:   rdata_o = both_o;
            SEL_POL:    rdata_o = pol_o;
            SEL_ENABLE: rdata_o = en_o;
            SEL_RAW:    rdata_o = raw_i;
            SEL_MASKED: rdata_o = masked_i;
            default:    rdata_o = '0;
        endcase
    end

    // R10: no write strobe leaves every configuration register stable
    a_r10_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(sense_o) && $stable(both_o) && $stable(pol_o) && $stable(en_o)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gid_pkg::*;
#(
    parameter int NUM_PINS     = 8,
    parameter int DIRECT_LINES = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic                  we_i,
    input  logic [SEL_W-1:0]      addr_i,
    input  logic [NUM_PINS-1:0]   wdata_i,
    output logic [NUM_PINS-1:0]   rdata_o,
    output logic [DIRECT_LINES:0] irq_o
);
    localparam int SHARED = DIRECT_LINES;

    logic [NUM_PINS-1:0] sync, prev;
    logic [NUM_PINS-1:0] sense, both, pol, en, clr;
    logic [NUM_PINS-1:0] raw, masked;

    gid_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(sync), .prev_o(prev)
    );

    gid_regs #(.W(NUM_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .raw_i(raw), .masked_i(masked), .sense_o(sense), .both_o(both),
        .pol_o(pol), .en_o(en), .clr_o(clr), .rdata_o(rdata_o)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gid_pin_detect u_det (
            .clk(clk), .rst_n(rst_n), .sync_i(sync[p]), .prev_i(prev[p]),
            .sense_i(sense[p]), .both_i(both[p]), .pol_i(pol[p]),
            .clr_i(clr[p]), .raw_o(raw[p])
        );
    end

    assign masked = raw & en;

    for (genvar k = 0; k < DIRECT_LINES; k++) begin : g_direct
        assign irq_o[k] = masked[k];
    end
    assign irq_o[SHARED] = |masked[NUM_PINS-1:SHARED];

    // R9: the shared line rises only with an enabled raw bit among the shared pins
    a_r9_shared_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[SHARED] |-> (|(raw[NUM_PINS-1:SHARED] & en[NUM_PINS-1:SHARED])));
    // R8: a disabled pin never reaches a direct line
    a_r8_masked_direct: assert property (@(posedge clk) disable iff (!rst_n)
        !en[0] |-> !irq_o[0]);
endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin = '0;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_detect u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference
    bit [7:0] m_s1, m_s2, m_prev, m_sense, m_both, m_pol, m_en, m_lat;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0;
            m_sense = 0; m_both = 0; m_pol = 0; m_en = 0; m_lat = 0;
        end else begin
            bit [7:0] nl;
            for (int p = 0; p < 8; p++) begin
                bit up, dn, ev, cl;
                up = m_s2[p] && !m_prev[p];
                dn = !m_s2[p] && m_prev[p];
                if (m_both[p]) ev = up || dn;          // R5
                else if (m_pol[p]) ev = up;            // R4
                else ev = dn;
                cl = we && addr == 3'd6 && wdata[p];   // R6
                if (m_sense[p]) nl[p] = 1'b0;          // R3
                else nl[p] = ev || (m_lat[p] && !cl);  // R7
            end
            m_lat = nl;
            if (we) begin                               // R2, R10
                case (addr)
                    3'd0: m_sense = wdata;
                    3'd1: m_both = wdata;
                    3'd2: m_pol = wdata;
                    3'd3: m_en = wdata;
                    default: ;
                endcase
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    function automatic bit [7:0] model_raw();
        bit [7:0] r;
        for (int p = 0; p < 8; p++)
            r[p] = m_sense[p] ? (m_pol[p] ? m_s2[p] : !m_s2[p]) : m_lat[p];
        return r;
    endfunction

    function automatic bit [7:0] model_read(input bit [2:0] a);
        case (a)
            3'd0: return m_sense;
            3'd1: return m_both;
            3'd2: return m_pol;
            3'd3: return m_en;
            3'd4: return model_raw();
            3'd5: return model_raw() & m_en;   // R8
            default: return 8'h00;            // R10
        endcase
    endfunction

    function automatic string read_req(input bit [2:0] a);
        case (a)
            3'd0, 3'd1, 3'd2, 3'd3: return "R2";
            3'd4: return "R3/R4/R5/R6/R7";
            3'd5: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic compare();
        bit [7:0] mr, exp_rd;
        bit [3:0] exp_irq;
        mr = model_raw() & m_en;
        exp_irq = {|mr[7:3], mr[2:0]};           // R9
        exp_rd = model_read(addr);
        compared++;
        if (irq !== exp_irq) begin
            mismatched++;
            $display("FAIL %s irq: actual %b expected %b", rst_n ? "R9" : "R1", irq, exp_irq);
        end
        compared++;
        if (rdata !== exp_rd) begin
            mismatched++;
            $display("FAIL %s read sel %0d: actual %h expected %h",
                     rst_n ? read_req(addr) : "R1", addr, rdata, exp_rd);
        end
    endtask

    task automatic step(input bit [7:0] p, input bit w, input bit [2:0] a, input bit [7:0] d);
        @(negedge clk);
        compare();
        pin = p; we = w; addr = a; wdata = d;
    endtask

    task automatic idle(input int n, input bit [2:0] a);
        for (int i = 0; i < n; i++) step(pin, 1'b0, a, 8'h00);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 4; i++) step(8'h00, 1'b0, 3'(i), 8'h00);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) step(8'h00, 1'b0, 3'(a), 8'h00);

        // R2: configure, R3: level pins 0 and 1
        step(8'h00, 1'b1, 3'd0, 8'h03);
        step(8'h00, 1'b1, 3'd2, 8'h01);
        step(8'h00, 1'b1, 3'd3, 8'hFF);
        step(8'h01, 1'b0, 3'd4, 8'h00);
        idle(3, 3'd4);
        step(8'h03, 1'b1, 3'd6, 8'hFF);   // R3: clear ignored on level pins
        idle(3, 3'd4);
        step(8'h00, 1'b0, 3'd5, 8'h00);
        idle(3, 3'd5);

        // R4: edge pin 2 rising, pin 3 falling
        step(8'h08, 1'b1, 3'd0, 8'h00);
        step(8'h08, 1'b1, 3'd2, 8'h04);
        idle(3, 3'd4);
        step(8'h04, 1'b0, 3'd4, 8'h00);   // pin2 up, pin3 down
        idle(4, 3'd4);
        step(8'h04, 1'b1, 3'd6, 8'h04);   // R6: clear pin2 only
        idle(2, 3'd4);
        step(8'h04, 1'b1, 3'd6, 8'h08);
        idle(2, 3'd5);

        // R7: edge and clear on the same edge for pin 2
        step(8'h00, 1'b0, 3'd4, 8'h00);
        idle(2, 3'd4);
        step(8'h04, 1'b0, 3'd4, 8'h00);
        idle(4, 3'd4);                    // pin 2 pending
        step(8'h00, 1'b0, 3'd4, 8'h00);
        idle(3, 3'd4);
        step(8'h04, 1'b0, 3'd4, 8'h00);   // rise captured at edge k
        step(8'h04, 1'b0, 3'd4, 8'h00);   // edge k+1
        step(8'h04, 1'b1, 3'd6, 8'h04);   // clear lands with the edge
        idle(3, 3'd4);

        // R5: both edges on pin 5 with polarity 0
        step(8'h04, 1'b1, 3'd1, 8'h20);
        step(8'h24, 1'b0, 3'd4, 8'h00);
        idle(4, 3'd4);
        step(8'h24, 1'b1, 3'd6, 8'hFF);
        idle(2, 3'd4);
        step(8'h04, 1'b0, 3'd4, 8'h00);
        idle(4, 3'd5);

        // R3: switch pending edge pin to level and back
        step(8'h04, 1'b1, 3'd0, 8'h20);
        idle(2, 3'd4);
        step(8'h04, 1'b1, 3'd0, 8'h00);
        idle(2, 3'd4);

        // R10: writes to status and spare selects
        step(8'h04, 1'b1, 3'd4, 8'hFF);
        step(8'h04, 1'b1, 3'd5, 8'hFF);
        step(8'h04, 1'b1, 3'd7, 8'hFF);
        for (int a = 0; a < 8; a++) step(8'h04, 1'b0, 3'(a), 8'h00);

        // random traffic: R2..R10 together
        for (int i = 0; i < 6000; i++) begin
            bit [7:0] p;
            bit w;
            p = pin;
            if ($urandom_range(0, 3) == 0) p = pin ^ 8'($urandom_range(0, 255));
            w = ($urandom_range(0, 4) == 0);
            step(p, w, 3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)));
        end
        idle(2, 3'd5);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule